// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block timestamps external events. A down counter runs at one of two tick rates, chosen by `fast_sel`, while the capture mode is on. Two input pins each have their own capture register. Each pin passes through a two-flop synchronizer and one delay stage. When the selected edge appears at the end of that chain, the current count is copied into the pin's register. Software reads elapsed time by subtracting two captured values, and it can read the registers while the counter keeps running.

Bits of the `mode` input set the behaviour. Bit 1 switches capture mode on. Bit 0 picks the edge polarity of pin A and bit 2 picks the edge polarity of pin B. This gives four capture codes: 010, 011, 110 and 111. A counter wrap from zero sets its own sticky underflow flag. Interrupt line A is shared by two sources: capture A and counter underflow. Both are gated by enable A, so the handler must look at both flags to find the cause. Interrupt line B serves capture B alone.

Top module: `dual_capture_timer`

## Requirements
- R1: While reset is asserted, both capture registers, all three pending flags and both interrupt lines are 0, and the counter is 0.
- R2: With `mode[1]`=1, the counter decreases by one on each clock in which the selected tick is high. The selected tick is `tick_fast` when `fast_sel`=1 and `tick_slow` when `fast_sel`=0. The tick that is not selected has no effect.
- R3: `mode[0]` selects the active edge of pin A and `mode[2]` selects the active edge of pin B. A value of 0 means rising and 1 means falling. An edge of the other direction captures nothing and sets no flag.
- R4: Suppose a pin changes before clock edge k. The pin's capture register then takes the counter value present at clock edge k+2, and it shows that value after edge k+2.
- R5: A capture on A sets `pend_a` and a capture on B sets `pend_b`. Each flag stays set until its clear strobe is high in a cycle with no new capture.
- R6: A selected tick while the counter is 0 reloads the counter with all ones and sets `pend_uf`.
- R7: `pend_uf` is cleared by `clr_uf`. It is also cleared on the clock at which `mode[1]` goes from 0 to 1.
- R8: `irq_a` is high when `en_a` is high and either `pend_a` or `pend_uf` is high. `irq_b` is high when `en_b` and `pend_b` are both high.
- R9: When both pins give an active edge in the same cycle, both registers take the same count.
- R10: With `mode[1]`=0, the counter holds its value, pin edges capture nothing and set no flag, and no underflow is raised.
- R11: A capture register keeps its value while the counter runs, until the next active edge on its own pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_slow | input | 1 | Slow-rate count enable |
| tick_fast | input | 1 | Fast-rate count enable |
| fast_sel | input | 1 | 1 selects tick_fast, 0 selects tick_slow |
| mode | input | 3 | Bit1 capture on, bit0 pin A falling, bit2 pin B falling |
| pin_a | input | 1 | Asynchronous event input A |
| pin_b | input | 1 | Asynchronous event input B |
| en_a | input | 1 | Enable for interrupt line A (capture A and underflow) |
| en_b | input | 1 | Enable for interrupt line B |
| clr_a | input | 1 | Clear strobe for pend_a |
| clr_b | input | 1 | Clear strobe for pend_b |
| clr_uf | input | 1 | Clear strobe for pend_uf |
| cap_a | output | CNT_W | Capture register A |
| cap_b | output | CNT_W | Capture register B |
| pend_a | output | 1 | Capture A pending |
| pend_b | output | 1 | Capture B pending |
| pend_uf | output | 1 | Counter underflow pending |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
The assertions assume that `mode` changes only between clock edges. The bench drives `mode` and every other input at the falling clock edge. The assertions also assume that an event pin, once changed, holds its level long enough for the synchronizer chain to settle before the next change. The bench waits at least four cycles after each pin change before it changes the pin again or changes the polarity bits. This means a transition still inside the chain is never judged under a new polarity. The counter width is cut to 8 bits, so a full wrap costs only 256 ticks.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    localparam int MODE_W      = 3;
    localparam int MODE_ON_BIT = 1;
    localparam int POL_A_BIT   = 0;
    localparam int POL_B_BIT   = 2;
endpackage

// File: rtl/dct_edge_sync.sv
module dct_edge_sync
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_pol_e pol,
    input  logic      arm,
    output logic      hit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   dly;
    } sync_t;

    sync_t s_d, s_q;
    logic  lvl;

    assign lvl = s_q.chain[SYNC_STAGES-1];

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], pin};
        s_d.dly   = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        if (pol == EDGE_RISE) hit = arm & lvl & ~s_q.dly;
        else                  hit = arm & ~lvl & s_q.dly;
    end
endmodule

// File: rtl/dct_down_counter.sv
module dct_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             step;

    assign step = run & tick;
    assign wrap = step & (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
    import dct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              fast_sel,
    input  logic [MODE_W-1:0] mode,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              clr_a,
    input  logic              clr_b,
    input  logic              clr_uf,
    output logic [CNT_W-1:0]  cap_a,
    output logic [CNT_W-1:0]  cap_b,
    output logic              pend_a,
    output logic              pend_b,
    output logic              pend_uf,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cap_a;
        logic [CNT_W-1:0] cap_b;
        logic             pend_a;
        logic             pend_b;
        logic             pend_uf;
        logic             on;
    } state_t;

    state_t           st_d, st_q;
    logic             cap_on;
    logic             tick_sel;
    logic             wrap;
    logic             entry;
    logic [CNT_W-1:0] cnt;
    logic [NCH-1:0]   pin_v;
    logic [NCH-1:0]   hit;
    edge_pol_e        pol_v [NCH];

    assign cap_on   = mode[MODE_ON_BIT];
    assign tick_sel = fast_sel ? tick_fast : tick_slow;
    assign pin_v    = {pin_b, pin_a};
    assign pol_v[0] = edge_pol_e'(mode[POL_A_BIT]);
    assign pol_v[1] = edge_pol_e'(mode[POL_B_BIT]);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dct_edge_sync #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_v[ch]),
            .pol  (pol_v[ch]),
            .arm  (cap_on),
            .hit  (hit[ch])
        );
    end

    dct_down_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (cap_on),
        .tick (tick_sel),
        .cnt  (cnt),
        .wrap (wrap)
    );

    always_comb begin
        st_d    = st_q;
        entry   = cap_on & ~st_q.on;
        st_d.on = cap_on;
        if (hit[0]) st_d.cap_a = cnt;
        if (hit[1]) st_d.cap_b = cnt;
        st_d.pend_a = hit[0] | (st_q.pend_a & ~clr_a);
        st_d.pend_b = hit[1] | (st_q.pend_b & ~clr_b);
        if (entry) st_d.pend_uf = 1'b0;
        else       st_d.pend_uf = wrap | (st_q.pend_uf & ~clr_uf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_a   = st_q.cap_a;
    assign cap_b   = st_q.cap_b;
    assign pend_a  = st_q.pend_a;
    assign pend_b  = st_q.pend_b;
    assign pend_uf = st_q.pend_uf;
    assign irq_a   = en_a & (st_q.pend_a | st_q.pend_uf);
    assign irq_b   = en_b & st_q.pend_b;
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic             clr_a,
    input logic [CNT_W-1:0] cap_a,
    input logic [CNT_W-1:0] cap_b,
    input logic             pend_a,
    input logic             pend_b,
    input logic             pend_uf
);
    // R5: a pending flag with no clear strobe stays set
    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a && !clr_a) |=> pend_a);

    // R7: entering capture mode leaves the underflow flag clear
    assert_uf_clear_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode[1]) |=> !pend_uf);

    // R10: capture registers are frozen outside capture mode
    assert_no_capture_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> ($stable(cap_a) && $stable(cap_b)));

    // R6: an underflow flag can only rise after a cycle in capture mode
    assert_uf_only_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_uf) |-> $past(mode[1]));

    // R11: capture register A changes only alongside its pending flag
    assert_cap_a_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_a) |-> pend_a);

    // R11: capture register B changes only alongside its pending flag
    assert_cap_b_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_b) |-> pend_b);
endmodule

bind dual_capture_timer dct_checker #(
    .CNT_W(CNT_W)
) u_dct_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .clr_a  (clr_a),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .pend_a (pend_a),
    .pend_b (pend_b),
    .pend_uf(pend_uf)
);

// File: tb/dual_capture_timer_bench.sv
module dual_capture_timer_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_slow = 1'b0, tick_fast = 1'b0, fast_sel = 1'b0;
    logic [2:0]   mode = 3'b010;
    logic         pin_a = 1'b0, pin_b = 1'b0;
    logic         en_a = 1'b0, en_b = 1'b0;
    logic         clr_a = 1'b0, clr_b = 1'b0, clr_uf = 1'b0;
    logic [W-1:0] cap_a, cap_b;
    logic         pend_a, pend_b, pend_uf, irq_a, irq_b;

    int           vecs = 0;
    int           fails = 0;
    logic [W-1:0] mdl;

    always #4 clk = ~clk;

    dual_capture_timer #(.CNT_W(W), .SYNC_STAGES(2)) u_dual_capture_timer (
        .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .fast_sel(fast_sel), .mode(mode), .pin_a(pin_a), .pin_b(pin_b),
        .en_a(en_a), .en_b(en_b), .clr_a(clr_a), .clr_b(clr_b), .clr_uf(clr_uf),
        .cap_a(cap_a), .cap_b(cap_b), .pend_a(pend_a), .pend_b(pend_b),
        .pend_uf(pend_uf), .irq_a(irq_a), .irq_b(irq_b)
    );

    // Counter model from R2/R6/R10
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdl <= '0;
        else if (mode[1] && (fast_sel ? tick_fast : tick_slow)) mdl <= mdl - 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ticks(input int n, input bit fast);
        fast_sel = fast;
        if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
        idle(n);
        tick_fast = 1'b0;
        tick_slow = 1'b0;
    endtask

    task automatic strobe(input bit a, input bit b, input bit u);
        clr_a = a; clr_b = b; clr_uf = u;
        idle(1);
        clr_a = 1'b0; clr_b = 1'b0; clr_uf = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [2:0]   codes [4];
        logic [W-1:0] exp_v;
        codes[0] = 3'b010; codes[1] = 3'b110; codes[2] = 3'b011; codes[3] = 3'b111;

        // R1 reset state
        idle(3);
        chk("R1 cap_a", cap_a, 0);
        chk("R1 cap_b", cap_b, 0);
        chk("R1 flags", {pend_a, pend_b, pend_uf}, 0);
        chk("R1 irqs", {irq_a, irq_b}, 0);
        rst_n = 1'b1;
        idle(3);

        // R6 underflow from 0, R8 gating by en_a
        run_ticks(1, 1'b0);
        chk("R6 pend_uf after wrap", pend_uf, 1);
        chk("R8 irq_a masked", irq_a, 0);
        en_a = 1'b1;
        idle(1);
        chk("R8 irq_a from underflow", irq_a, 1);
        chk("R8 irq_b quiet", irq_b, 0);
        strobe(1'b0, 1'b0, 1'b1);
        chk("R7 clr_uf", pend_uf, 0);
        chk("R8 irq_a after clear", irq_a, 0);

        // R7 mode entry clears underflow; R10 off-mode holds everything
        run_ticks(255, 1'b1);
        chk("R6 no early wrap", pend_uf, 0);
        run_ticks(1, 1'b1);
        chk("R6 second wrap", pend_uf, 1);
        mode = 3'b000;
        idle(2);
        pin_a = 1'b1;
        run_ticks(5, 1'b0);
        idle(4);
        chk("R10 cap_a frozen", cap_a, 0);
        chk("R10 pend_a quiet", pend_a, 0);
        mode = 3'b010;
        idle(2);
        chk("R7 entry clears pend_uf", pend_uf, 0);
        pin_a = 1'b0;
        idle(4);
        pin_a = 1'b1;
        idle(4);
        chk("R10 counter held at all ones", cap_a, 8'hFF);
        strobe(1'b1, 1'b1, 1'b1);
        en_b = 1'b1;

        // R3 R4 R5 polarity sweep
        for (int m = 0; m < 4; m++) begin
            logic act_a, act_b;
            mode  = codes[m];
            act_a = ~codes[m][0];
            act_b = ~codes[m][2];
            pin_a = ~act_a;
            pin_b = ~act_b;
            idle(5);
            strobe(1'b1, 1'b1, 1'b1);
            run_ticks(m + 3, m[0]);
            pin_a = act_a;
            idle(4);
            exp_v = mdl;
            chk("R4 cap_a on active edge", cap_a, exp_v);
            chk("R5 pend_a set", pend_a, 1);
            chk("R5 pend_b untouched", pend_b, 0);
            chk("R8 irq_a from capture", irq_a, 1);
            strobe(1'b1, 1'b0, 1'b0);
            chk("R5 clr_a", pend_a, 0);
            run_ticks(2, ~m[0]);
            pin_a = ~act_a;
            idle(4);
            chk("R3 cap_a ignores other edge", cap_a, exp_v);
            chk("R3 pend_a ignores other edge", pend_a, 0);
            run_ticks(m + 1, 1'b1);
            pin_b = act_b;
            idle(4);
            exp_v = mdl;
            chk("R4 cap_b on active edge", cap_b, exp_v);
            chk("R5 pend_b set", pend_b, 1);
            chk("R8 irq_b", irq_b, 1);
            strobe(1'b0, 1'b1, 1'b0);
            chk("R5 clr_b", pend_b, 0);
            run_ticks(3, 1'b0);
            pin_b = ~act_b;
            idle(4);
            chk("R3 cap_b ignores other edge", cap_b, exp_v);
            chk("R3 pend_b ignores other edge", pend_b, 0);
        end

        // R9 simultaneous edges
        mode = 3'b010;
        pin_a = 1'b0; pin_b = 1'b0;
        idle(5);
        run_ticks(7, 1'b1);
        pin_a = 1'b1; pin_b = 1'b1;
        idle(4);
        chk("R9 cap_a shared count", cap_a, mdl);
        chk("R9 cap_b shared count", cap_b, mdl);

        // R2 unselected tick has no effect
        exp_v = mdl;
        fast_sel = 1'b1; tick_slow = 1'b1;
        idle(6);
        tick_slow = 1'b0;
        pin_b = 1'b0;
        idle(4);
        pin_b = 1'b1;
        idle(4);
        chk("R2 unselected tick ignored", cap_b, exp_v);

        // R4 R11 capture while counting
        pin_a = 1'b0;
        fast_sel = 1'b1; tick_fast = 1'b1;
        idle(4);
        pin_a = 1'b1;
        idle(2);
        exp_v = mdl;
        idle(1);
        chk("R4 capture while running", cap_a, exp_v);
        idle(5);
        chk("R11 cap_a held while running", cap_a, exp_v);
        tick_fast = 1'b0;
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule